// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches each bus cycle that the core issues towards the external bus. It flags any cycle that does not complete in time. A transfer start arms a timer. A transfer acknowledge that closes a single-beat cycle disarms it. Inside a burst, every beat acknowledge restarts the timer, so each beat gets the full allowance. If the timer reaches the programmed limit first, the block emits a one-clock transfer-error pulse that the bus logic treats as an error termination.

Time is measured in prescaled ticks of eight system clocks. The 8-bit limit therefore spans 8 to 2040 clocks, and a limit of zero selects 256 ticks. The prescaler restarts together with the timer, so the resolution is exactly eight clocks. An enable input switches the monitor on. The monitor is also active while freeze is high or a debug request is pending, whatever the enable says. All pins are plain level or pulse controls with no handshake. The configuration inputs are expected to be held steady by the register logic that owns them.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: With the monitor active and limit N in 1..255, let E be the rising edge that samples `xfer_start` high. If no acknowledge follows, `xfer_err` is high for the clock period that begins at the 8·N-th rising edge after E.
- R2: An acknowledge sampled while `burst_active` is low ends the cycle, and no error follows it.
- R3: An acknowledge sampled while `burst_active` is high restarts the timing. The error then appears 8·N edges after the edge that sampled that acknowledge.
- R4: An acknowledge sampled on the same edge at which the timeout would fire takes priority, and no error is raised on that edge.
- R5: `xfer_err` is high for exactly one clock period. After it, the monitor stays idle and raises no further error until the next transfer start.
- R6: A limit of 0 acts as 256 ticks, so the error appears 2048 edges after E.
- R7: With `mon_en`, `freeze` and `dbg_pend` all low, no error is ever raised.
- R8: `freeze` high, or `dbg_pend` high, makes the monitor active while `mon_en` is low.
- R9: While `rst_n` is low, `xfer_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Pulse: a bus cycle begins |
| xfer_ack | input | 1 | Pulse: a beat or the cycle is acknowledged |
| burst_active | input | 1 | High while the current cycle is a burst |
| mon_en | input | 1 | Monitor enable |
| timeout_sel | input | 8 | Timeout in units of eight clocks; 0 means 256 |
| freeze | input | 1 | Freeze state; forces the monitor on |
| dbg_pend | input | 1 | Debug request pending; forces the monitor on |
| xfer_err | output | 1 | One-clock transfer-error pulse |

## Verification
A prescaler that drifts moves the error pulse by single clocks away from a multiple of eight. A miscounting tick counter moves it by whole multiples of eight. Either fault is visible on the first timed cycle of the sweep over limits. A state register that fails to clear shows up as a second pulse, or a missing one, within one further timeout window after an acknowledge or an error. A wrong priority between acknowledge and timeout shows up as a pulse on the exact edge of the collision.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_TIMING = 1'b1
  } bcw_state_e;
endpackage

// File: rtl/bcw_prescaler.sv
module bcw_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic wrap
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign wrap = run && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (clear)  phase_q <= '0;
    else if (run)    phase_q <= wrap ? '0 : phase_q + PW'(1);
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);

  // R1
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (phase_q == '0));
endmodule

// File: rtl/bcw_tick_counter.sv
module bcw_tick_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] ticks
);
  logic [W-1:0] ticks_q;

  assign ticks = ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ticks_q <= '0;
    else if (clear) ticks_q <= '0;
    else if (inc)   ticks_q <= ticks_q + W'(1);
  end

  // R6
  tick_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear) |-> (ticks_q != {W{1'b1}}));
endmodule

// File: rtl/bus_cycle_watchdog.sv
module bus_cycle_watchdog #(
  parameter int unsigned DIV = 8,
  parameter int unsigned W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer_start,
  input  logic         xfer_ack,
  input  logic         burst_active,
  input  logic         mon_en,
  input  logic [W-1:0] timeout_sel,
  input  logic         freeze,
  input  logic         dbg_pend,
  output logic         xfer_err
);
  import bcw_pkg::*;

  bcw_state_e   state_q;
  logic         busy;
  logic         active;
  logic         restart;
  logic         terminal;
  logic         wrap;
  logic [W-1:0] ticks;
  logic [W-1:0] lim_m1;
  logic         err_q;

  assign busy     = (state_q == ST_TIMING);
  assign active   = mon_en | freeze | dbg_pend;
  assign lim_m1   = timeout_sel - W'(1);
  assign restart  = xfer_start | (busy & xfer_ack & burst_active);
  assign terminal = busy && wrap && (ticks == lim_m1) && !xfer_ack && !xfer_start;

  bcw_prescaler #(.DIV(DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .run   (busy),
    .wrap  (wrap)
  );

  bcw_tick_counter #(.W(W)) u_ticks (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart | terminal),
    .inc   (wrap),
    .ticks (ticks)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (xfer_start) begin
      state_q <= ST_TIMING;
    end else if (busy) begin
      if (xfer_ack && !burst_active) state_q <= ST_IDLE;
      else if (terminal)             state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= terminal & active;
  end

  assign xfer_err = err_q;

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !xfer_err);

  // R5
  idle_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> (state_q == ST_IDLE));

  // R4
  ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> !$past(xfer_ack));

  // R7
  err_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> $past(mon_en | freeze | dbg_pend));

  // R9
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!err_q);
    end
  end
endmodule

// File: tb/bus_cycle_watchdog_tb.sv
`timescale 1ns/1ps
module bus_cycle_watchdog_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_start = 1'b0;
  logic       xfer_ack = 1'b0;
  logic       burst_active = 1'b0;
  logic       mon_en = 1'b0;
  logic [7:0] timeout_sel = 8'd0;
  logic       freeze = 1'b0;
  logic       dbg_pend = 1'b0;
  logic       xfer_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_cycle_watchdog u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_start   (xfer_start),
    .xfer_ack     (xfer_ack),
    .burst_active (burst_active),
    .mon_en       (mon_en),
    .timeout_sel  (timeout_sel),
    .freeze       (freeze),
    .dbg_pend     (dbg_pend),
    .xfer_err     (xfer_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts one cycle and watches it. ack_k/ack2_k: acks driven in the clock
  // period that ends at edge number k after the start edge (-1 = none).
  // err_k: index of the edge after which the first error was seen.
  task automatic run_cycle(input int lim, input bit burst, input int ack_k,
                           input int ack2_k, input int window,
                           output int err_k, output int err_n);
    err_k = -1;
    err_n = 0;
    timeout_sel  = lim[7:0];
    burst_active = burst;
    @(negedge clk);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    for (int k = 1; k <= window; k++) begin
      if (xfer_err) begin
        if (err_k < 0) err_k = k - 1;
        err_n++;
      end
      xfer_ack = (k == ack_k) || (k == ack2_k);
      @(negedge clk);
    end
    xfer_ack = 1'b0;
    burst_active = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ek;
    int en;
    repeat (3) @(negedge clk);
    check(xfer_err == 1'b0, "R9", xfer_err, 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (2) @(negedge clk);

    // R1 / R5: sweep of small limits, long window to catch a repeat
    for (int n = 1; n <= 8; n++) begin
      run_cycle(n, 1'b0, -1, -1, 16 * n + 6, ek, en);
      check(ek == 8 * n, "R1", ek, 8 * n);
      check(en == 1, "R5", en, 1);
    end

    // R6: limit zero means 256 ticks
    run_cycle(0, 1'b0, -1, -1, 2048 + 10, ek, en);
    check(ek == 2048, "R6", ek, 2048);

    // R2 and R4 for several limits
    for (int n = 1; n <= 4; n++) begin
      run_cycle(n, 1'b0, 8 * n - 1, -1, 16 * n + 6, ek, en);
      check(en == 0, "R2", en, 0);
      run_cycle(n, 1'b0, 8 * n, -1, 16 * n + 6, ek, en);
      check(en == 0, "R4", en, 0);
      run_cycle(n, 1'b1, 8 * n, -1, 24 * n + 6, ek, en);
      check(ek == 16 * n, "R4", ek, 16 * n);
    end

    // R3: one beat ack at every offset
    for (int a = 1; a <= 12; a++) begin
      run_cycle(2, 1'b1, a, -1, a + 40, ek, en);
      check(ek == a + 16, "R3", ek, a + 16);
      check(en == 1, "R3", en, 1);
    end
    run_cycle(3, 1'b1, 5, 12, 70, ek, en);
    check(ek == 36, "R3", ek, 36);

    // R7: monitor off
    mon_en = 1'b0;
    run_cycle(2, 1'b0, -1, -1, 40, ek, en);
    check(en == 0, "R7", en, 0);

    // R8: forced on by freeze, then by debug request
    freeze = 1'b1;
    run_cycle(2, 1'b0, -1, -1, 40, ek, en);
    check(ek == 16, "R8", ek, 16);
    freeze = 1'b0;
    dbg_pend = 1'b1;
    run_cycle(3, 1'b0, -1, -1, 40, ek, en);
    check(ek == 24, "R8", ek, 24);
    dbg_pend = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule